// File: doc/BRIEF.md
# Per-Channel Mean/Median Averaging Unit

This unit sits between a multi-channel successive-approximation converter and its result queue. Each raw conversion arrives with a channel number. The unit looks up that channel's settings in a packed control word. Depending on those settings, it either forwards the sample at once or gathers a group of 2, 4 or 8 samples from the same channel and reduces the group to one result. The reduction is either the truncated arithmetic mean or the median. The converter side can hold off new conversions while the averaging-busy output is high.

The control word holds two 2-bit fields per channel. One selects the reduction: 0 forwards samples unchanged, 1 takes the mean, 2 takes the median, and 3 is reserved and also forwards. The other holds the log2 of the group size. A group's settings and channel are captured from its first sample.

The controller has four states. IDLE waits for a sample. COLLECT gathers the rest of a group. SORT runs one compare-exchange pass per cycle over the stored group. PICK loads the median into the output register.

The transitions are as follows:
- IDLE to COLLECT: a sample arrives whose channel asks for a multi-sample group.
- COLLECT to IDLE: the last sample of a mean group arrives (the result is loaded on the same edge), or a sample from another channel arrives whose settings ask for forwarding.
- COLLECT to COLLECT: a sample from another channel arrives that starts a new group.
- COLLECT to SORT: the last sample of a median group arrives.
- SORT to PICK: after N passes.
- PICK to IDLE: always, one cycle later.

Top module: `chan_avg_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` and `avg_busy` are low.
- R2: Channel c's mode sits at `avg_ctrl[2c+17:2c+16]` and its group-size code n at `avg_ctrl[2c+1:2c]`. The group size is 2^n, giving 1, 2, 4 or 8. Changing one channel's fields leaves every other channel's behaviour unchanged.
- R3: With mode 0, or the reserved mode 3, each sample is forwarded with its data and channel on the edge that accepts it. Back-to-back samples give back-to-back results, and `avg_busy` stays low.
- R4: With mode 1 and group size N > 1, the result is the sum of the N samples shifted right by n, with truncation. It is loaded on the edge that accepts the last sample. Idle cycles between samples are allowed.
- R5: With mode 2 and N > 1, the result is the lower of the two middle values of the sorted group, which is the entry at index (N-1)/2 in ascending order. It is loaded N+1 edges after the edge that accepts the last sample.
- R6: With mode 1 or 2 and a group size of 1, the sample is forwarded on the edge that accepts it.
- R7: `avg_busy` is high from the edge that accepts the first sample of a multi-sample group until the edge that loads its result, and low otherwise. It is never high in a cycle where `out_valid` is high.
- R8: During COLLECT, a sample carrying a different channel discards the partial group without producing any output. That sample is then handled as the first sample under its own channel's settings.
- R9: Samples presented during SORT or PICK are dropped. They change neither the pending median nor the number of results.
- R10: `out_chan` carries the channel of the group or forwarded sample that the result belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| avg_ctrl | input | MODE_LSB+2*NUM_CH (32) | Packed per-channel mode and group-size fields |
| in_valid | input | 1 | Raw sample strobe |
| in_chan | input | log2(NUM_CH) (3) | Channel of the raw sample |
| in_data | input | DATA_W (12) | Raw sample value |
| out_valid | output | 1 | One-cycle result strobe |
| out_chan | output | log2(NUM_CH) (3) | Channel of the result |
| out_data | output | DATA_W (12) | Result value |
| avg_busy | output | 1 | High while a multi-sample group is in progress |

## Verification
Forwarded samples, single-sample groups and mean results are all loaded on the same edge that accepts the final sample. The bench therefore counts the cycles from the falling edge right after that acceptance and expects the strobe at a count of 1. A median over N samples is due at a count of N+2, because the N sort passes and the PICK cycle come in between. The bench compares the measured count against that figure for every vector. Where samples are expected to be ignored, the bench drives them in exactly the SORT and PICK cycles, then confirms that the strobe still appears at its fixed position with an unchanged value and that no second strobe follows.

// File: rtl/chan_avg_pkg.sv
package chan_avg_pkg;

    localparam int AVG_MODE_W = 2;
    localparam int AVG_CODE_W = 2;

    typedef enum logic [AVG_MODE_W-1:0] {
        AVG_PASS   = 2'd0,
        AVG_MEAN   = 2'd1,
        AVG_MEDIAN = 2'd2,
        AVG_RSVD   = 2'd3
    } avg_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_SORT,
        ST_PICK
    } avg_state_e;

endpackage

// File: rtl/chan_avg_cfg_sel.sv
module chan_avg_cfg_sel
    import chan_avg_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int MODE_LSB = 16,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int CTRL_W  = MODE_LSB + AVG_MODE_W * NUM_CH
) (
    input  logic [CTRL_W-1:0]     ctrl,
    input  logic [CH_W-1:0]       chan,
    output avg_mode_e             mode,
    output logic [AVG_CODE_W-1:0] log_size
);

    logic [AVG_MODE_W-1:0] mode_fld [NUM_CH];
    logic [AVG_CODE_W-1:0] code_fld [NUM_CH];

    // unpack the per-channel fields; the positions are fixed by the register layout
    for (genvar c = 0; c < NUM_CH; c++) begin : g_field
        assign mode_fld[c] = ctrl[MODE_LSB + AVG_MODE_W*c +: AVG_MODE_W];
        assign code_fld[c] = ctrl[AVG_CODE_W*c +: AVG_CODE_W];
    end

    assign mode     = avg_mode_e'(mode_fld[chan]);
    assign log_size = code_fld[chan];

endmodule

// File: rtl/chan_avg_sorter.sv
module chan_avg_sorter #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pass_en,
    input  logic              pass_odd,
    input  logic [IDX_W-1:0]  sel_idx,
    output logic [DATA_W-1:0] sel_data
);

    localparam logic [DATA_W-1:0] PAD = '1;

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [DATA_W-1:0] swept  [DEPTH];

    // odd-even transposition: pair (j, j+1) is active when j's parity equals pass_odd.
    // Unused slots hold the all-ones pad so they never move below real samples.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cx
        localparam logic I_ODD = 1'(i % 2);
        if (i == 0) begin : g_first
            always_comb begin
                swept[i] = slot_q[i];
                if (pass_odd == I_ODD && slot_q[i] > slot_q[i+1])
                    swept[i] = slot_q[i+1];
            end
        end else if (i == DEPTH - 1) begin : g_last
            always_comb begin
                swept[i] = slot_q[i];
                if (pass_odd != I_ODD && slot_q[i-1] > slot_q[i])
                    swept[i] = slot_q[i-1];
            end
        end else begin : g_mid
            always_comb begin
                swept[i] = slot_q[i];
                if (pass_odd == I_ODD) begin
                    if (slot_q[i] > slot_q[i+1])
                        swept[i] = slot_q[i+1];
                end else begin
                    if (slot_q[i-1] > slot_q[i])
                        swept[i] = slot_q[i-1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++)
                slot_q[k] <= PAD;
        end else if (clear) begin
            for (int k = 0; k < DEPTH; k++)
                slot_q[k] <= (wr_en && wr_idx == IDX_W'(k)) ? wr_data : PAD;
        end else if (wr_en) begin
            slot_q[wr_idx] <= wr_data;
        end else if (pass_en) begin
            for (int k = 0; k < DEPTH; k++)
                slot_q[k] <= swept[k];
        end
    end

    assign sel_data = slot_q[sel_idx];

endmodule

// File: rtl/chan_avg_unit.sv
module chan_avg_unit
    import chan_avg_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int DATA_W   = 12,
    parameter int MODE_LSB = 16,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int CTRL_W  = MODE_LSB + AVG_MODE_W * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] avg_ctrl,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [CH_W-1:0]   out_chan,
    output logic [DATA_W-1:0] out_data,
    output logic              avg_busy
);

    localparam int MAX_LOG = (1 << AVG_CODE_W) - 1;
    localparam int DEPTH   = 1 << MAX_LOG;
    localparam int IDX_W   = MAX_LOG;
    localparam int SUM_W   = DATA_W + MAX_LOG;

    avg_state_e state_q, state_d;

    avg_mode_e             in_mode;
    logic [AVG_CODE_W-1:0] in_log;

    logic [CH_W-1:0]       cur_chan_q;
    avg_mode_e             cur_mode_q;
    logic [AVG_CODE_W-1:0] cur_log_q;
    logic [IDX_W-1:0]      cnt_q;
    logic [IDX_W-1:0]      pass_q;
    logic [SUM_W-1:0]      sum_q;

    logic [IDX_W:0]        grp_size;
    logic [IDX_W-1:0]      grp_last;
    logic [SUM_W-1:0]      sum_next;
    logic [DATA_W-1:0]     mean_val;
    logic [DATA_W-1:0]     med_val;

    logic in_multi, same_chan, take_new, take_add, take_last;

    chan_avg_cfg_sel #(
        .NUM_CH   (NUM_CH),
        .MODE_LSB (MODE_LSB)
    ) u_cfg (
        .ctrl     (avg_ctrl),
        .chan     (in_chan),
        .mode     (in_mode),
        .log_size (in_log)
    );

    always_comb begin
        grp_size  = (IDX_W+1)'(1) << cur_log_q;
        grp_last  = IDX_W'(grp_size - 1'b1);
        sum_next  = sum_q + SUM_W'(in_data);
        mean_val  = DATA_W'(sum_next >> cur_log_q);
        in_multi  = (in_mode == AVG_MEAN || in_mode == AVG_MEDIAN) && (in_log != '0);
        same_chan = (in_chan == cur_chan_q);
        take_new  = in_valid && ((state_q == ST_IDLE) ||
                                 (state_q == ST_COLLECT && !same_chan));
        take_add  = in_valid && (state_q == ST_COLLECT) && same_chan;
        take_last = take_add && (cnt_q == grp_last);
    end

    chan_avg_sorter #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_sort (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (take_new),
        .wr_en    (take_new || take_add),
        .wr_idx   (take_new ? '0 : cnt_q),
        .wr_data  (in_data),
        .pass_en  (state_q == ST_SORT),
        .pass_odd (pass_q[0]),
        .sel_idx  (grp_last >> 1),
        .sel_data (med_val)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && in_multi)
                    state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (in_valid) begin
                    if (!same_chan)
                        state_d = in_multi ? ST_COLLECT : ST_IDLE;
                    else if (cnt_q == grp_last)
                        state_d = (cur_mode_q == AVG_MEDIAN) ? ST_SORT : ST_IDLE;
                end
            end
            ST_SORT: begin
                if (pass_q == grp_last)
                    state_d = ST_PICK;
            end
            ST_PICK: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // datapath and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_chan_q <= '0;
            cur_mode_q <= AVG_PASS;
            cur_log_q  <= '0;
            cnt_q      <= '0;
            pass_q     <= '0;
            sum_q      <= '0;
            out_valid  <= 1'b0;
            out_chan   <= '0;
            out_data   <= '0;
        end else begin
            out_valid <= 1'b0;
            if (take_new) begin
                cur_chan_q <= in_chan;
                cur_mode_q <= in_mode;
                cur_log_q  <= in_log;
                cnt_q      <= IDX_W'(1);
                pass_q     <= '0;
                sum_q      <= SUM_W'(in_data);
                if (!in_multi) begin
                    out_valid <= 1'b1;
                    out_chan  <= in_chan;
                    out_data  <= in_data;
                end
            end else if (take_add) begin
                cnt_q <= cnt_q + 1'b1;
                sum_q <= sum_next;
                if (take_last && cur_mode_q == AVG_MEAN) begin
                    out_valid <= 1'b1;
                    out_chan  <= cur_chan_q;
                    out_data  <= mean_val;
                end
            end
            if (state_q == ST_SORT)
                pass_q <= pass_q + 1'b1;
            if (state_q == ST_PICK) begin
                out_valid <= 1'b1;
                out_chan  <= cur_chan_q;
                out_data  <= med_val;
            end
        end
    end

    assign avg_busy = (state_q != ST_IDLE);

endmodule

// File: rtl/chan_avg_unit_chk.sv
module chan_avg_unit_chk #(
    parameter int NUM_CH   = 8,
    parameter int DATA_W   = 12,
    parameter int MODE_LSB = 16,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int CTRL_W  = MODE_LSB + 2 * NUM_CH
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] avg_ctrl,
    input logic              in_valid,
    input logic [CH_W-1:0]   in_chan,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [CH_W-1:0]   out_chan,
    input logic [DATA_W-1:0] out_data,
    input logic              avg_busy
);

    logic [1:0] chk_mode, chk_code;
    logic       chk_single;

    always_comb begin
        chk_mode   = avg_ctrl[MODE_LSB + 2*int'(in_chan) +: 2];
        chk_code   = avg_ctrl[2*int'(in_chan) +: 2];
        chk_single = (chk_mode == 2'd0) || (chk_mode == 2'd3) || (chk_code == 2'd0);
    end

    // R3 / R6 / R10: an idle unit forwards a single-sample request on the next edge
    assert_forward_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!avg_busy && in_valid && chk_single) |=>
            (out_valid && out_data == $past(in_data) && out_chan == $past(in_chan)));

    // R7: never busy while presenting a result
    assert_busy_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !avg_busy);

    // R7: busy only rises after an accepted sample
    assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avg_busy) |-> $past(in_valid));

    // R9: a result needs either a sample or an active group in the previous cycle
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid) || $past(avg_busy)));

    // R3: idle and no sample means no result next cycle
    assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!avg_busy && !in_valid) |=> !out_valid);

endmodule

bind chan_avg_unit chan_avg_unit_chk #(
    .NUM_CH   (NUM_CH),
    .DATA_W   (DATA_W),
    .MODE_LSB (MODE_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .avg_ctrl  (avg_ctrl),
    .in_valid  (in_valid),
    .in_chan   (in_chan),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_data  (out_data),
    .avg_busy  (avg_busy)
);

// File: tb/chan_avg_unit_test.sv
`timescale 1ns/1ps
module chan_avg_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] avg_ctrl;
    logic        in_valid;
    logic [2:0]  in_chan;
    logic [11:0] in_data;
    logic        out_valid;
    logic [2:0]  out_chan;
    logic [11:0] out_data;
    logic        avg_busy;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    chan_avg_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .avg_ctrl  (avg_ctrl),
        .in_valid  (in_valid),
        .in_chan   (in_chan),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_chan  (out_chan),
        .out_data  (out_data),
        .avg_busy  (avg_busy)
    );

    typedef struct packed {
        logic [2:0]  chan;
        logic [1:0]  mode;
        logic [1:0]  code;
        logic        gap;
        logic [95:0] smp;   // first sample in the top 12 bits
        logic [11:0] expv;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 2'd1, 2'd3, 1'b0, {12'd10, 12'd20, 12'd30, 12'd40, 12'd50, 12'd60, 12'd70, 12'd81}, 12'd45},
        '{3'd1, 2'd2, 2'd3, 1'b1, {12'd900, 12'd5, 12'd300, 12'd4095, 12'd7, 12'd300, 12'd12, 12'd1000}, 12'd300},
        '{3'd2, 2'd2, 2'd2, 1'b0, {12'd40, 12'd10, 12'd30, 12'd20, 48'd0}, 12'd20},
        '{3'd3, 2'd1, 2'd2, 1'b1, {12'd4095, 12'd4095, 12'd4095, 12'd4094, 48'd0}, 12'd4094},
        '{3'd4, 2'd0, 2'd3, 1'b0, {12'd1234, 84'd0}, 12'd1234},
        '{3'd5, 2'd3, 2'd2, 1'b0, {12'd77, 84'd0}, 12'd77},
        '{3'd6, 2'd1, 2'd0, 1'b0, {12'd999, 84'd0}, 12'd999},
        '{3'd7, 2'd2, 2'd1, 1'b0, {12'd500, 12'd100, 72'd0}, 12'd100},
        '{3'd0, 2'd2, 2'd0, 1'b0, {12'd3, 84'd0}, 12'd3},
        '{3'd7, 2'd1, 2'd1, 1'b1, {12'd3, 12'd4, 72'd0}, 12'd3}
    };

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic set_fields(input int ch, input logic [1:0] m, input logic [1:0] c);
        avg_ctrl[16 + 2*ch +: 2] = m;
        avg_ctrl[2*ch +: 2]      = c;
    endtask

    task automatic send(input int ch, input int d);
        @(negedge clk);
        in_valid = 1'b1;
        in_chan  = 3'(ch);
        in_data  = 12'(d);
    endtask

    // called right after the last send; lat counts falling edges after the accepting edge
    task automatic wait_out(output bit got, output int lat);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        got = out_valid;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    int  n, exp_lat, lat, outs;
    bit  got;
    string tag;

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_chan  = '0;
        in_data  = '0;
        avg_ctrl = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(avg_busy == 1'b0, "R1 busy in reset", int'(avg_busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && avg_busy == 1'b0, "R1 after release",
              int'({out_valid, avg_busy}), 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            n = (TBL[v].mode == 2'd1 || TBL[v].mode == 2'd2) ? (1 << TBL[v].code) : 1;
            exp_lat = (TBL[v].mode == 2'd2 && n > 1) ? n + 2 : 1;
            if (TBL[v].mode == 2'd0 || TBL[v].mode == 2'd3) tag = "R3";
            else if (n == 1)                                tag = "R6";
            else if (TBL[v].mode == 2'd1)                   tag = "R4";
            else                                            tag = "R5";
            set_fields(int'(TBL[v].chan), TBL[v].mode, TBL[v].code);
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                if (i == 1)
                    check(avg_busy == 1'b1, "R7 busy during group", int'(avg_busy), 1);
                if (TBL[v].gap && i > 0) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                in_valid = 1'b1;
                in_chan  = TBL[v].chan;
                in_data  = TBL[v].smp[95 - 12*i -: 12];
            end
            wait_out(got, lat);
            check(got, {tag, " result strobe"}, int'(got), 1);
            check(out_data == TBL[v].expv, {tag, " result value"}, int'(out_data), int'(TBL[v].expv));
            check(lat == exp_lat, {tag, " result latency"}, lat, exp_lat);
            check(out_chan == TBL[v].chan, "R10 result channel", int'(out_chan), int'(TBL[v].chan));
            check(avg_busy == 1'b0, "R7 busy low with result", int'(avg_busy), 0);
        end

        // R2: neighbour fields do not leak into channel 2
        set_fields(2, 2'd0, 2'd0);
        set_fields(3, 2'd2, 2'd3);
        set_fields(1, 2'd1, 2'd3);
        send(2, 42);
        wait_out(got, lat);
        check(got && out_data == 12'd42 && lat == 1, "R2 field isolation", int'(out_data), 42);

        // R8: abort into a forwarded sample
        set_fields(0, 2'd1, 2'd2);
        set_fields(1, 2'd0, 2'd0);
        send(0, 100);
        send(0, 200);
        send(1, 555);
        wait_out(got, lat);
        check(got && lat == 1 && out_data == 12'd555, "R8 abort to forward", int'(out_data), 555);
        check(out_chan == 3'd1, "R8 forward channel", int'(out_chan), 1);
        check(avg_busy == 1'b0, "R8 partial group dropped", int'(avg_busy), 0);

        // R8: abort into a new mean group on another channel
        set_fields(0, 2'd1, 2'd1);
        set_fields(2, 2'd1, 2'd1);
        send(0, 1000);
        send(2, 6);
        send(2, 8);
        wait_out(got, lat);
        check(got && lat == 1 && out_data == 12'd7, "R8 restart mean", int'(out_data), 7);
        check(out_chan == 3'd2, "R8 restart channel", int'(out_chan), 2);

        // R9: samples during SORT and PICK are dropped
        set_fields(1, 2'd2, 2'd1);
        send(1, 500);
        send(1, 100);
        outs = 0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (out_valid) begin
                outs++;
                check(k == 4, "R9 median latency", k, 4);
                check(out_data == 12'd100, "R9 median unchanged", int'(out_data), 100);
            end
            if (k <= 3) begin
                in_valid = 1'b1;
                in_chan  = 3'd1;
                in_data  = 12'd0;
            end else begin
                in_valid = 1'b0;
            end
        end
        check(outs == 1, "R9 single result", outs, 1);
        check(avg_busy == 1'b0, "R9 idle afterwards", int'(avg_busy), 0);

        // R3: back-to-back forwarding
        set_fields(4, 2'd0, 2'd3);
        send(4, 1);
        for (int k = 2; k <= 4; k++) begin
            @(negedge clk);
            check(out_valid && out_data == 12'(k - 1), "R3 stream",
                  int'(out_data), k - 1);
            check(avg_busy == 1'b0, "R3 busy stays low", int'(avg_busy), 0);
            if (k <= 3) begin
                in_valid = 1'b1;
                in_chan  = 3'd4;
                in_data  = 12'(k);
            end else begin
                in_valid = 1'b0;
            end
        end

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule